// File: doc/BRIEF.md
# Bandwidth-Throttled Memory Response Scheduler

This block fronts a small word-addressed storage array. A requester hands it reads and writes on a valid/ready request channel. The storage access is performed in the cycle the request is taken. A response, when the request asks for one, is placed in a short queue together with the cycle at which it may leave. Responses leave on a valid/ready response channel. The same channel can also withdraw a response and present it again on a retry pin. A throttle limits the short-term data rate: each accepted request holds off the next one for a number of cycles set by its byte count and a per-byte cost pin.

Back-pressure works as follows. `req_ready` is low while the throttle is busy, while the queue is full, while a retry is owed, or while the presented command is not a read or a write. If a legal request is presented while `req_ready` is low, the block owes the requester a retry. It pulses `req_retry` for one cycle once it is neither busy nor full, and it raises `req_ready` in the following cycle. On the response side, a presented response that sees `rsp_ready` low at a clock edge is withdrawn: `rsp_valid` drops. It stays down until `rsp_retry` is sampled high, and it returns in the next cycle.

The queue is ordered by due cycle, with two limits. A new entry never overtakes an entry that targets the same line. It also never overtakes the head, which may already be on the port. `drained` tells a power or reset controller whether any response is still pending.

Top module: `bwmem_sched`

## Requirements
- R1: After a request is accepted, `req_ready` stays low for exactly `req_size * cfg_cost` cycles and then returns high, provided no retry is owed and the queue is not full.
- R2: When `req_size * cfg_cost` is zero, the block does not become busy, and `req_ready` is high in the cycle right after the acceptance.
- R3: A legal request that is presented while `req_ready` is low makes the block owe a retry. `req_retry` is high for exactly one cycle: the first cycle in which the throttle is idle and the queue is not full. `req_ready` stays low through that cycle and rises in the next one.
- R4: Command codes 2'b00 (read) and 2'b01 (write) are legal. Codes 2'b10 and 2'b11 raise `cmd_err` while they are presented with `req_valid`. They are never accepted and never make a retry owed.
- R5: A response's due cycle is the acceptance cycle plus `req_hdr_dly` plus `req_pay_dly` plus the parameter LAT. At the head of an unblocked queue, `rsp_valid` first rises in exactly that cycle.
- R6: A new entry is placed ahead of trailing entries only while its due cycle is strictly earlier than theirs and their line differs from its line. It stops behind the first same-line entry, and it never goes ahead of the head entry.
- R7: Two addresses belong to the same line when they agree above the low log2(LINE_BYTES) bits (64 bytes by default).
- R8: If `rsp_valid` is high and `rsp_ready` is low at a clock edge, `rsp_valid` is low from the next cycle on. It is high again in the cycle after `rsp_retry` is sampled high.
- R9: A request with `req_want_rsp` low still updates or reads the storage, but it creates no queue entry.
- R10: With DEPTH entries queued, `req_ready` is low even when the throttle is idle.
- R11: `drained` is high exactly when the response queue is empty.
- R12: A read response carries the storage word at acceptance time, including earlier writes, with `rsp_wr` low. A write response carries the written word with `rsp_wr` high. The word index is address bits [log2(DATA_W/8) +: log2(MEM_WORDS)].
- R13: The cycle counter and due cycles are 32-bit and wrap. A due cycle past the wrap point is not treated as already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cost | input | COST_W | Busy cycles charged per request byte |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cmd | input | 2 | Command code (00 read, 01 write) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_size | input | SIZE_W | Request size in bytes |
| req_hdr_dly | input | DLY_W | Header delay in cycles |
| req_pay_dly | input | DLY_W | Payload delay in cycles |
| req_want_rsp | input | 1 | Request expects a response |
| req_retry | output | 1 | One-cycle retry notice to the requester |
| cmd_err | output | 1 | Illegal command presented |
| rsp_valid | output | 1 | Response presented |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | ADDR_W | Address of the response |
| rsp_data | output | DATA_W | Response data |
| rsp_wr | output | 1 | Response belongs to a write |
| rsp_retry | input | 1 | Present a withdrawn response again |
| drained | output | 1 | No response pending |

## Verification
The throttle is registered: after an acceptance edge, `req_ready` is sampled at the following falling edges, and the bench expects exactly size times cost low samples before it rises. A response is due hdr+pay+LAT cycles after its acceptance cycle; the first falling-edge sample after acceptance counts as one, so the bench expects `rsp_valid` at sample count total-1. Retry pulses are expected one cycle after the throttle empties, with `req_ready` rising one cycle later. A withdrawn response must be absent at the very next sample and present again one sample after the `rsp_retry` edge. Ordering is checked by the order in which responses leave, and the bench works the expected order out from due cycles computed from its own issue timing and from line numbers.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_WR  = 2'b01,
    CMD_RSV = 2'b10,
    CMD_BAD = 2'b11
  } mrs_cmd_e;

  function automatic logic cmd_legal(input logic [1:0] c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  // wrap-safe: a is strictly before b
  function automatic logic cyc_before(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    return d[31];
  endfunction
endpackage

// File: rtl/mrs_admit.sv
module mrs_admit
  import mrs_pkg::*;
#(
  parameter int SIZE_W = 4,
  parameter int COST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COST_W-1:0] cfg_cost,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              q_full,
  output logic              req_ready,
  output logic              accept,
  output logic              req_retry,
  output logic              cmd_err
);
  localparam int BW = SIZE_W + COST_W;

  logic [BW-1:0] busy_cnt;
  logic [BW-1:0] dur;
  logic          busy;
  logic          legal;
  logic          retry_pend;
  logic          refuse;

  assign legal     = cmd_legal(req_cmd);
  assign busy      = |busy_cnt;
  assign dur       = BW'(req_size) * BW'(cfg_cost);
  assign req_retry = retry_pend & ~busy & ~q_full;
  assign req_ready = legal & ~busy & ~q_full & ~retry_pend;
  assign accept    = req_valid & req_ready;
  assign refuse    = req_valid & legal & ~req_ready;
  assign cmd_err   = req_valid & ~legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt   <= '0;
      retry_pend <= 1'b0;
    end else begin
      if (accept)    busy_cnt <= dur;
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (req_retry) retry_pend <= 1'b0;
      else           retry_pend <= retry_pend | refuse;
    end
  end

  AST_BUSY_AFTER_COST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (dur != '0) |=> !req_ready) else $error("busy window missing"); // R1
  AST_ZERO_COST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (dur == '0) |=> busy_cnt == '0) else $error("zero cost went busy"); // R2
  AST_RETRY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    req_retry |=> !req_retry) else $error("retry longer than one cycle"); // R3
  AST_ILLEGAL_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !legal && !retry_pend |=> !retry_pend) else $error("illegal cmd owed retry"); // R4
endmodule

// File: rtl/mrs_store.sv
module mrs_store #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  localparam int IDX_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [MEM_WORDS];

  // a write returns the value it stores
  assign rdata = we ? wdata : mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/mrs_order_q.sv
module mrs_order_q
  import mrs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int LINE_LG = 6,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       now,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_wr,
  input  logic [31:0]       push_due,
  input  logic              rsp_ready,
  input  logic              rsp_retry,
  output logic              full,
  output logic              empty,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_wr
);
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];
  logic              e_wr   [DEPTH];
  logic [31:0]       e_due  [DEPTH];
  logic [ADDR_W-1:0] n_addr [DEPTH];
  logic [DATA_W-1:0] n_data [DEPTH];
  logic              n_wr   [DEPTH];
  logic [31:0]       n_due  [DEPTH];

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ins_pos;
  logic             hold;
  logic             due_hit;
  logic             pop;

  assign full      = (cnt == CNT_W'(DEPTH));
  assign empty     = (cnt == '0);
  assign due_hit   = !empty && !cyc_before(now, e_due[0]);
  assign rsp_valid = due_hit & ~hold;
  assign pop       = rsp_valid & rsp_ready;
  assign rsp_addr  = e_addr[0];
  assign rsp_data  = e_data[0];
  assign rsp_wr    = e_wr[0];

  // walk from the tail toward (but not past) the head
  always_comb begin
    logic stop;
    stop    = 1'b0;
    ins_pos = cnt;
    for (int j = DEPTH - 1; j >= 1; j--) begin
      if (j < int'(cnt) && !stop) begin
        if (cyc_before(push_due, e_due[j]) &&
            (e_addr[j][ADDR_W-1:LINE_LG] != push_addr[ADDR_W-1:LINE_LG]))
          ins_pos = CNT_W'(j);
        else
          stop = 1'b1;
      end
    end
  end

  always_comb begin
    int pos;
    int src;
    pos = pop ? int'(ins_pos) - 1 : int'(ins_pos);
    for (int i = 0; i < DEPTH; i++) begin
      src = pop ? i + 1 : i;
      n_addr[i] = e_addr[i];
      n_data[i] = e_data[i];
      n_wr[i]   = e_wr[i];
      n_due[i]  = e_due[i];
      if (push && i == pos) begin
        n_addr[i] = push_addr;
        n_data[i] = push_data;
        n_wr[i]   = push_wr;
        n_due[i]  = push_due;
      end else if (push && i > pos) begin
        n_addr[i] = e_addr[src-1];
        n_data[i] = e_data[src-1];
        n_wr[i]   = e_wr[src-1];
        n_due[i]  = e_due[src-1];
      end else if (src < DEPTH) begin
        n_addr[i] = e_addr[src];
        n_data[i] = e_data[src];
        n_wr[i]   = e_wr[src];
        n_due[i]  = e_due[src];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= '0;
        e_data[i] <= '0;
        e_wr[i]   <= 1'b0;
        e_due[i]  <= '0;
      end
    end else begin
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      if (rsp_retry)                   hold <= 1'b0;
      else if (rsp_valid && !rsp_ready) hold <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= n_addr[i];
        e_data[i] <= n_data[i];
        e_wr[i]   <= n_wr[i];
        e_due[i]  <= n_due[i];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push into full queue"); // R10
  AST_REFUSED_WITHDRAWN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready && !rsp_retry |=> !rsp_valid) else $error("refused rsp kept"); // R8
  AST_HEAD_NOT_DISPLACED: assert property (@(posedge clk) disable iff (!rst_n)
    push && !empty && !pop |=> $stable(e_addr[0]) && $stable(e_due[0])) else $error("head overtaken"); // R6
endmodule

// File: rtl/bwmem_sched.sv
module bwmem_sched
  import mrs_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter int          SIZE_W     = 4,
  parameter int          COST_W     = 4,
  parameter int          DLY_W      = 8,
  parameter int          LAT        = 4,
  parameter int          DEPTH      = 8,
  parameter int          LINE_BYTES = 64,
  parameter int          MEM_WORDS  = 64,
  parameter logic [31:0] CNT_INIT   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COST_W-1:0] cfg_cost,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DLY_W-1:0]  req_hdr_dly,
  input  logic [DLY_W-1:0]  req_pay_dly,
  input  logic              req_want_rsp,
  output logic              req_retry,
  output logic              cmd_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_wr,
  input  logic              rsp_retry,
  output logic              drained
);
  localparam int LINE_LG = $clog2(LINE_BYTES);
  localparam int OFF_LG  = $clog2(DATA_W / 8);
  localparam int IDX_W   = $clog2(MEM_WORDS);

  logic [31:0]       now;
  logic [31:0]       due;
  logic              accept;
  logic              q_full;
  logic              q_empty;
  logic              is_wr;
  logic [DATA_W-1:0] acc_data;

  always_ff @(posedge clk) begin
    if (!rst_n) now <= CNT_INIT;
    else        now <= now + 32'd1;
  end

  assign due     = now + 32'(req_hdr_dly) + 32'(req_pay_dly) + 32'(LAT);
  assign is_wr   = (req_cmd == CMD_WR);
  assign drained = q_empty;

  mrs_admit #(.SIZE_W(SIZE_W), .COST_W(COST_W)) u_admit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_cost  (cfg_cost),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_size  (req_size),
    .q_full    (q_full),
    .req_ready (req_ready),
    .accept    (accept),
    .req_retry (req_retry),
    .cmd_err   (cmd_err)
  );

  mrs_store #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (accept & is_wr),
    .idx   (req_addr[OFF_LG +: IDX_W]),
    .wdata (req_wdata),
    .rdata (acc_data)
  );

  mrs_order_q #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH (DEPTH), .LINE_LG (LINE_LG)
  ) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .now       (now),
    .push      (accept & req_want_rsp),
    .push_addr (req_addr),
    .push_data (acc_data),
    .push_wr   (is_wr),
    .push_due  (due),
    .rsp_ready (rsp_ready),
    .rsp_retry (rsp_retry),
    .full      (q_full),
    .empty     (q_empty),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_data  (rsp_data),
    .rsp_wr    (rsp_wr)
  );
endmodule

// File: tb/bwmem_sched_bench.sv
`timescale 1ns/100ps
module bwmem_sched_bench;
  localparam int LAT = 3;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_cost = '0;
  logic req_valid = 1'b0, req_ready, req_want_rsp = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_size = '0;
  logic [7:0] req_hdr_dly = '0, req_pay_dly = '0;
  logic req_retry, cmd_err, rsp_valid, rsp_wr, drained;
  logic rsp_ready = 1'b1, rsp_retry = 1'b0;
  logic [11:0] rsp_addr;
  logic [31:0] rsp_data;
  int n_chk = 0, n_bad = 0;
  logic [11:0] got_a;
  logic [31:0] got_d;
  logic got_w;

  always #2 clk = ~clk;

  bwmem_sched #(.LAT(LAT), .DEPTH(DEPTH), .CNT_INIT(32'hFFFF_FFF0)) u_bwmem_sched (
    .clk(clk), .rst_n(rst_n), .cfg_cost(cfg_cost),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .req_hdr_dly(req_hdr_dly), .req_pay_dly(req_pay_dly), .req_want_rsp(req_want_rsp),
    .req_retry(req_retry), .cmd_err(cmd_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .rsp_wr(rsp_wr), .rsp_retry(rsp_retry), .drained(drained)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nxt;
    @(negedge clk); #1;
  endtask

  task automatic issue(input logic [1:0] c, input logic [11:0] a, input logic [31:0] d,
                       input int sz, input int hd, input int pd, input logic want);
    int g;
    req_cmd = c; req_addr = a; req_wdata = d; req_size = 4'(sz);
    req_hdr_dly = 8'(hd); req_pay_dly = 8'(pd); req_want_rsp = want; req_valid = 1'b1;
    #0.5;
    g = 0;
    while (!req_ready && g < 500) begin nxt; g++; end
    @(posedge clk); nxt;
    req_valid = 1'b0; req_cmd = 2'b00;
  endtask

  task automatic wait_rsp;
    int g;
    g = 0;
    while (!rsp_valid && g < 500) begin nxt; g++; end
    got_a = rsp_addr; got_d = rsp_data; got_w = rsp_wr;
    nxt;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL ALL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("reset req_ready R1", 32'(req_ready), 1);
    chk("reset rsp_valid R8", 32'(rsp_valid), 0);
    chk("reset drained R11", 32'(drained), 1);
    chk("reset req_retry R3", 32'(req_retry), 0);

    // R13: due crosses the 32-bit wrap of the counter
    issue(2'b00, 12'h000, 0, 1, 25, 7, 1'b1);
    m = 0;
    while (!rsp_valid && m < 300) begin nxt; m++; end
    chk("R13 wrap due", 32'(m), 32'(25 + 7 + LAT - 1));
    nxt;

    // R5: due-time sweep
    for (int h = 0; h < 4; h++) begin
      for (int p = 0; p < 3; p++) begin
        issue(2'b00, 12'(h * 64 + p * 4), 0, 1, h * 3, p * 2, 1'b1);
        m = 0;
        while (!rsp_valid && m < 300) begin nxt; m++; end
        chk("R5 due cycle", 32'(m), 32'(h * 3 + p * 2 + LAT - 1));
        chk("R5 rsp addr", 32'(rsp_addr), 32'(h * 64 + p * 4));
        nxt;
      end
    end

    // R1 / R2: busy-window sweep over size and cost
    for (int s = 1; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        cfg_cost = 4'(c);
        issue(2'b01, 12'h3F0, 32'h1, s, 0, 0, 1'b0);
        m = 0;
        while (!req_ready && m < 100) begin nxt; m++; end
        if (s * c == 0) chk("R2 zero cost not busy", 32'(m), 0);
        else            chk("R1 busy window", 32'(m), 32'(s * c));
      end
    end
    cfg_cost = 0;

    // R9 / R12: posted writes, then reads back
    for (int i = 0; i < 8; i++) begin
      issue(2'b01, 12'(12'h300 + 4 * i), 32'(i * 32'h1111 + 7), 4, 0, 0, 1'b0);
      chk("R9 posted write leaves queue empty", 32'(drained), 1);
    end
    for (int i = 0; i < 8; i++) begin
      issue(2'b00, 12'(12'h300 + 4 * i), 0, 4, 0, 0, 1'b1);
      wait_rsp;
      chk("R12 read data after write", got_d, 32'(i * 32'h1111 + 7));
      chk("R12 read kind", 32'(got_w), 0);
    end
    issue(2'b01, 12'h304, 32'hCAFE_0042, 4, 0, 0, 1'b1);
    wait_rsp;
    chk("R12 write rsp data", got_d, 32'hCAFE_0042);
    chk("R12 write rsp kind", 32'(got_w), 1);

    // R4: illegal commands
    for (int c = 2; c < 4; c++) begin
      req_cmd = 2'(c); req_valid = 1'b1; #0.5;
      chk("R4 cmd_err", 32'(cmd_err), 1);
      chk("R4 not ready", 32'(req_ready), 0);
      for (int k = 0; k < 3; k++) begin
        nxt;
        chk("R4 no retry", 32'(req_retry), 0);
      end
      req_valid = 1'b0; req_cmd = 2'b00;
      nxt;
      chk("R4 ready after illegal", 32'(req_ready), 1);
      chk("R4 cmd_err cleared", 32'(cmd_err), 0);
    end

    // R3: refused while busy, retry timing
    cfg_cost = 4;
    issue(2'b01, 12'h3F8, 32'h2, 2, 0, 0, 1'b0);
    cfg_cost = 0;
    req_cmd = 2'b00; req_addr = 12'h3FC; req_size = 0; req_want_rsp = 1'b0; req_valid = 1'b1;
    #0.5;
    chk("R3 refused while busy", 32'(req_ready), 0);
    begin
      int seen;
      logic rdy_at;
      seen = -1; rdy_at = 1'b1;
      for (int k = 0; k < 40; k++) begin
        if (req_retry) begin seen = k; rdy_at = req_ready; break; end
        nxt;
      end
      chk("R3 retry cycle", 32'(seen), 8);
      chk("R3 not ready in retry cycle", 32'(rdy_at), 0);
    end
    nxt;
    chk("R3 retry one cycle", 32'(req_retry), 0);
    chk("R3 ready after retry", 32'(req_ready), 1);
    @(posedge clk); nxt;
    req_valid = 1'b0;

    // R6 / R7: ordered insertion sweep
    for (int hi = 0; hi < 4; hi++) begin
      for (int ai = 0; ai < 4; ai++) begin
        int hc;
        logic [11:0] ac;
        logic ahead;
        hc = (hi == 0) ? 0 : (hi == 1) ? 28 : (hi == 2) ? 29 : 60;
        ac = (ai == 0) ? 12'h0C0 : (ai == 1) ? 12'h050 : (ai == 2) ? 12'h07F : 12'h080;
        ahead = (hc < 29) && (ac[11:6] != 6'h01);
        issue(2'b00, 12'h000, 0, 1, 30, 0, 1'b1);
        issue(2'b00, 12'h040, 0, 1, 30, 0, 1'b1);
        issue(2'b00, ac, 0, 1, hc, 0, 1'b1);
        wait_rsp;
        chk("R6 head first", 32'(got_a), 32'h000);
        wait_rsp;
        chk("R6 R7 second rsp", 32'(got_a), ahead ? 32'(ac) : 32'h040);
        wait_rsp;
        chk("R6 R7 third rsp", 32'(got_a), ahead ? 32'h040 : 32'(ac));
      end
    end

    // R10 / R11: full queue refusal and drain
    for (int i = 0; i < DEPTH; i++) issue(2'b00, 12'(12'h100 + 64 * i), 0, 1, 40, 0, 1'b1);
    chk("R11 not drained", 32'(drained), 0);
    req_cmd = 2'b00; req_addr = 12'h200; req_size = 1; req_hdr_dly = 0; req_want_rsp = 1'b1;
    req_valid = 1'b1;
    #0.5;
    chk("R10 refused when full", 32'(req_ready), 0);
    begin
      logic saw;
      int g;
      saw = 1'b0; g = 0;
      while (!req_ready && g < 300) begin
        if (req_retry) saw = 1'b1;
        nxt; g++;
      end
      chk("R10 retry after slot frees", 32'(saw), 1);
    end
    @(posedge clk); nxt;
    req_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) wait_rsp;
    chk("R11 drained after last rsp", 32'(drained), 1);

    // R8: response refused, withdrawn, retried
    rsp_ready = 1'b0;
    issue(2'b00, 12'h020, 0, 1, 0, 0, 1'b1);
    m = 0;
    while (!rsp_valid && m < 50) begin nxt; m++; end
    chk("R8 first presented", 32'(rsp_valid), 1);
    nxt;
    chk("R8 withdrawn", 32'(rsp_valid), 0);
    for (int k = 0; k < 3; k++) begin
      nxt;
      chk("R8 stays withdrawn", 32'(rsp_valid), 0);
    end
    rsp_retry = 1'b1;
    nxt;
    rsp_retry = 1'b0;
    chk("R8 presented again", 32'(rsp_valid), 1);
    chk("R8 same addr", 32'(rsp_addr), 32'h020);
    rsp_ready = 1'b1;
    nxt;
    chk("R11 drained after retry", 32'(drained), 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule